// File: doc/BRIEF.md
# Event-Activated Descriptor Transfer Engine

This block moves data on behalf of peripherals without CPU involvement. Each peripheral raises a level request, such as a "receive data ready" flag. When the request is enabled, the engine takes a descriptor index from that source's vector slot. It reads the descriptor from an internal register file and performs one single-beat read followed by one single-beat write on a memory bus. It then updates the descriptor's addresses and count and writes them back. A descriptor may chain to the next descriptor, and the engine runs the whole chain within one activation.

After the last link, the engine does one of two things. It may clear the peripheral's flag through a clear pulse. Otherwise it hands the event to the CPU as an interrupt pulse. When a normal-mode count expires, it also switches the source off.

The bus master side follows valid/ready rules. A beat is offered with `bus_valid` and completes on the first rising edge where `bus_ready` is also high. While the beat waits, the address, direction, size and write data do not change, so the responder may apply back-pressure for any number of cycles. Read data is taken in the completing cycle. Descriptors, vector slots and the enable mask are loaded and inspected through a plain configuration port while the engine is idle.

Top module: `evt_xfer_engine`

## Requirements
- R1: Among sources whose request and enable bit are both high, the lowest-numbered source is served first. A source whose enable bit is low is never served, and produces no bus activity.
- R2: Configuration port word map, with NDESC=8 and NSRC=4:
  - Descriptor k occupies words 4k..4k+3, holding mode, source address, destination address and count.
  - Word 32+s is the vector slot of source s, giving a descriptor index.
  - Word 36 is the enable mask, with bit s for source s.
  - An activation of source s starts at the descriptor named by its vector slot.
- R3: A transfer reads one word from the source address and writes that same word to the destination address.
- R4: Mode bits [1:0] set the source address update and bits [3:2] set the destination address update. The codes are 00/01 fixed, 10 increment and 11 decrement. Size bits [7:6] set the step: 00 gives 1, 01 gives 2, 1x gives 4.
- R5: In normal mode (mode bits [5:4] not 01), the 16-bit count decrements by one per transfer. The updated addresses and count are written back before the engine is idle again.
- R6: When the last link's normal count reaches zero, the source's enable bit is cleared and an interrupt pulse is raised for that source. No clear pulse is sent, so the peripheral's request stays high.
- R7: When the last link's count does not expire and mode bit 9 is 0, one clear pulse is sent for the source and no interrupt is raised.
- R8: When mode bit 9 of the last link is 1, an interrupt pulse is raised after every activation, no clear pulse is sent, and the enable bit is left unchanged unless the count expires.
- R9: When mode bit 8 is 1, the engine continues with descriptor index+1 in the same activation. Only the link with bit 8 at 0 may send a clear pulse, raise an interrupt or clear an enable bit.
- R10: In repeat mode (mode bits [5:4] = 01), count bits [7:0] hold the remaining count and bits [15:8] hold the reload value. When the remaining count reaches zero, it is reloaded and each non-fixed address returns to its starting value. The enable bit is never cleared.
- R11: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_we` and `bus_wdata` hold their values into the next cycle.
- R12: `busy` rises in the cycle after an activation is accepted. It falls in the cycle after the last descriptor write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req | input | NSRC | level requests from peripherals |
| req_clr | output | NSRC | one-cycle pulse clearing a peripheral flag |
| irq | output | NSRC | one-cycle pulse passing the event to the CPU |
| busy | output | 1 | activation in progress |
| bus_valid | output | 1 | bus beat offered |
| bus_we | output | 1 | 1 = write beat, 0 = read beat |
| bus_size | output | 2 | transfer size code of the beat |
| bus_addr | output | 16 | beat address |
| bus_wdata | output | 16 | write data |
| bus_ready | input | 1 | beat accepted |
| bus_rdata | input | 16 | read data, valid with bus_ready on a read beat |
| cfg_we | input | 1 | configuration write strobe |
| cfg_waddr | input | CAW | configuration write word address |
| cfg_wdata | input | 16 | configuration write data |
| cfg_raddr | input | CAW | configuration read word address |
| cfg_rdata | output | 16 | configuration read data (combinational) |

## Verification
The first pattern is a fixed-source, incrementing-destination byte stream run until its count expires. It separates the decrement path from the end-of-count path: an interrupt is raised instead of a clear pulse, the enable bit drops, and later requests are ignored. A word-size stream with an incrementing source and a decrementing destination runs under bus back-pressure, which tells step size and direction apart and exercises the hold rule. Simultaneous requests expose priority order. The remaining patterns are the per-transfer interrupt option, a two-link chain whose first link expires (an end-of-count that must stay silent), and a repeat-mode stream traced through its reload.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int WORD_W = 16;
  localparam int F_SM  = 0;
  localparam int F_DM  = 2;
  localparam int F_MD  = 4;
  localparam int F_SZ  = 6;
  localparam int F_CHN = 8;
  localparam int F_INT = 9;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t mode;
    word_t src;
    word_t dst;
    word_t cnt;
  } desc_t;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_WBACK} eng_st_e;

  function automatic word_t step_of(input logic [1:0] sz);
    case (sz)
      2'b00:   return word_t'(1);
      2'b01:   return word_t'(2);
      default: return word_t'(4);
    endcase
  endfunction

  function automatic word_t advance(input word_t a, input logic [1:0] f, input word_t s);
    case (f)
      2'b10:   return a + s;
      2'b11:   return a - s;
      default: return a;
    endcase
  endfunction

  function automatic word_t rewind(input word_t a, input logic [1:0] f, input word_t span);
    case (f)
      2'b10:   return a - span;
      2'b11:   return a + span;
      default: return a;
    endcase
  endfunction
endpackage

// File: rtl/xfer_desc_store.sv
module xfer_desc_store import xfer_pkg::*; #(
  parameter int NSRC  = 4,
  parameter int NDESC = 8,
  parameter int IW    = $clog2(NDESC),
  parameter int SW    = $clog2(NSRC),
  parameter int CAW   = $clog2(4*NDESC+NSRC+1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CAW-1:0]  cfg_waddr,
  input  word_t           cfg_wdata,
  input  logic [CAW-1:0]  cfg_raddr,
  output word_t           cfg_rdata,
  input  logic [IW-1:0]   rd_idx,
  output desc_t           rd_desc,
  input  logic [SW-1:0]   vec_src,
  output logic [IW-1:0]   vec_idx,
  output logic [NSRC-1:0] en,
  input  logic            wb_en,
  input  logic [IW-1:0]   wb_idx,
  input  word_t           wb_src,
  input  word_t           wb_dst,
  input  word_t           wb_cnt,
  input  logic [NSRC-1:0] en_clr
);
  localparam int DWORDS = 4*NDESC;
  localparam int DAW    = IW + 2;
  localparam logic [CAW-1:0] VEC_A = CAW'(DWORDS);
  localparam logic [CAW-1:0] EN_A  = CAW'(DWORDS + NSRC);

  word_t           dmem [DWORDS];
  logic [IW-1:0]   vec  [NSRC];
  logic [NSRC-1:0] en_n;

  always_comb begin
    en_n = en;
    if (cfg_we && cfg_waddr == EN_A) en_n = cfg_wdata[NSRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DWORDS; k++) dmem[k] <= '0;
      for (int s = 0; s < NSRC; s++) vec[s] <= '0;
      en <= '0;
    end else begin
      en <= en_n & ~en_clr;
      if (cfg_we && cfg_waddr < VEC_A) dmem[cfg_waddr[DAW-1:0]] <= cfg_wdata;
      for (int s = 0; s < NSRC; s++)
        if (cfg_we && cfg_waddr == VEC_A + CAW'(s)) vec[s] <= cfg_wdata[IW-1:0];
      if (wb_en) begin
        dmem[{wb_idx, 2'd1}] <= wb_src;
        dmem[{wb_idx, 2'd2}] <= wb_dst;
        dmem[{wb_idx, 2'd3}] <= wb_cnt;
      end
    end
  end

  assign rd_desc = '{mode: dmem[{rd_idx, 2'd0}], src: dmem[{rd_idx, 2'd1}],
                     dst: dmem[{rd_idx, 2'd2}], cnt: dmem[{rd_idx, 2'd3}]};
  assign vec_idx = vec[vec_src];

  always_comb begin
    cfg_rdata = '0;
    if (cfg_raddr < VEC_A) cfg_rdata = dmem[cfg_raddr[DAW-1:0]];
    else if (cfg_raddr == EN_A) cfg_rdata = word_t'(en);
    else
      for (int s = 0; s < NSRC; s++)
        if (cfg_raddr == VEC_A + CAW'(s)) cfg_rdata = word_t'(vec[s]);
  end

  // R6: a cleared enable bit is low in the following cycle
  p_en_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_clr) |=> ((en & $past(en_clr)) == '0));
endmodule

// File: rtl/xfer_prio.sv
module xfer_prio #(
  parameter int NSRC = 4,
  parameter int SW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] en,
  output logic            any,
  output logic [SW-1:0]   gidx
);
  logic [NSRC-1:0] act, gnt;
  assign act = req & en;

  for (genvar i = 0; i < NSRC; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign gnt[i] = act[i];
    end else begin : g_rest
      assign gnt[i] = act[i] & ~|act[i-1:0];
    end
  end

  always_comb begin
    gidx = '0;
    for (int i = 0; i < NSRC; i++) if (gnt[i]) gidx = SW'(i);
  end
  assign any = |act;

  // R1: never more than one source granted
  p_single_grant_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
endmodule

// File: rtl/xfer_step.sv
module xfer_step import xfer_pkg::*; (
  input  desc_t d,
  output word_t nsrc,
  output word_t ndst,
  output word_t ncnt,
  output logic  eoc
);
  logic [1:0] sm, dm, md, sz;
  word_t      step, span, asrc, adst;
  logic [7:0] rl, c8;
  logic       wrap;
  logic       unused_hi;

  assign sm   = d.mode[F_SM+1:F_SM];
  assign dm   = d.mode[F_DM+1:F_DM];
  assign md   = d.mode[F_MD+1:F_MD];
  assign sz   = d.mode[F_SZ+1:F_SZ];
  assign unused_hi = ^d.mode[WORD_W-1:F_CHN];
  assign step = step_of(sz);
  assign rl   = d.cnt[15:8];
  assign c8   = d.cnt[7:0] - 8'd1;
  assign span = word_t'(rl) << (sz == 2'b00 ? 0 : sz == 2'b01 ? 1 : 2);
  assign asrc = advance(d.src, sm, step);
  assign adst = advance(d.dst, dm, step);
  assign wrap = (md == 2'b01) && (c8 == 8'd0);

  always_comb begin
    if (md == 2'b01) begin
      nsrc = wrap ? rewind(asrc, sm, span) : asrc;
      ndst = wrap ? rewind(adst, dm, span) : adst;
      ncnt = wrap ? {rl, rl} : {rl, c8};
      eoc  = 1'b0;
    end else begin
      nsrc = asrc;
      ndst = adst;
      ncnt = d.cnt - word_t'(1);
      eoc  = (d.cnt == word_t'(1));
    end
  end
endmodule

// File: rtl/evt_xfer_engine.sv
module evt_xfer_engine import xfer_pkg::*; #(
  parameter int NSRC  = 4,
  parameter int NDESC = 8,
  parameter int CAW   = $clog2(4*NDESC+NSRC+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req,
  output logic [NSRC-1:0]   req_clr,
  output logic [NSRC-1:0]   irq,
  output logic              busy,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [1:0]        bus_size,
  output logic [15:0]       bus_addr,
  output logic [15:0]       bus_wdata,
  input  logic              bus_ready,
  input  logic [15:0]       bus_rdata,
  input  logic              cfg_we,
  input  logic [CAW-1:0]    cfg_waddr,
  input  logic [15:0]       cfg_wdata,
  input  logic [CAW-1:0]    cfg_raddr,
  output logic [15:0]       cfg_rdata
);
  localparam int IW = $clog2(NDESC);
  localparam int SW = $clog2(NSRC);

  eng_st_e         st;
  logic [SW-1:0]   src, gidx;
  logic [IW-1:0]   idx, vec_idx;
  word_t           dbuf, nsrc, ndst, ncnt;
  desc_t           cur;
  logic [NSRC-1:0] en, en_clr, src_oh;
  logic            any, eoc, chain, last, to_cpu;

  xfer_desc_store #(.NSRC(NSRC), .NDESC(NDESC), .IW(IW), .SW(SW), .CAW(CAW)) u_store (
    .clk, .rst_n, .cfg_we, .cfg_waddr, .cfg_wdata, .cfg_raddr, .cfg_rdata,
    .rd_idx(idx), .rd_desc(cur), .vec_src(gidx), .vec_idx, .en,
    .wb_en(st == ST_WBACK), .wb_idx(idx), .wb_src(nsrc), .wb_dst(ndst), .wb_cnt(ncnt),
    .en_clr);

  xfer_prio #(.NSRC(NSRC), .SW(SW)) u_prio (
    .clk, .rst_n, .req, .en, .any, .gidx);

  xfer_step u_step (.d(cur), .nsrc, .ndst, .ncnt, .eoc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      src  <= '0;
      idx  <= '0;
      dbuf <= '0;
    end else begin
      case (st)
        ST_IDLE: if (any) begin
          src <= gidx;
          idx <= vec_idx;
          st  <= ST_READ;
        end
        ST_READ: if (bus_ready) begin
          dbuf <= bus_rdata;
          st   <= ST_WRITE;
        end
        ST_WRITE: if (bus_ready) st <= ST_WBACK;
        default: begin
          if (chain) begin
            idx <= idx + IW'(1);
            st  <= ST_READ;
          end else begin
            st <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign chain     = cur.mode[F_CHN];
  assign last      = (st == ST_WBACK) && !chain;
  assign to_cpu    = eoc || cur.mode[F_INT];
  assign src_oh    = NSRC'(1) << src;
  assign irq       = (last && to_cpu)  ? src_oh : '0;
  assign req_clr   = (last && !to_cpu) ? src_oh : '0;
  assign en_clr    = (last && eoc)     ? src_oh : '0;
  assign busy      = (st != ST_IDLE);
  assign bus_valid = (st == ST_READ) || (st == ST_WRITE);
  assign bus_we    = (st == ST_WRITE);
  assign bus_addr  = (st == ST_WRITE) ? cur.dst : cur.src;
  assign bus_wdata = dbuf;
  assign bus_size  = cur.mode[F_SZ+1:F_SZ];

  // R11: an offered beat is held unchanged until accepted
  p_hold_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
  // R7: a source gets either a clear pulse or an interrupt, never both
  p_one_notice_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, req_clr}));
  // R6: disabling a source always comes with its interrupt
  p_disable_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_clr) |-> (irq == en_clr));
  // R12: busy falls right after the final write-back
  p_busy_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq || |req_clr) |=> !busy);
  // R9: notices only come from a write-back state
  p_notice_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq || |req_clr) |-> (st == ST_WBACK));
endmodule

// File: tb/sim_evt_xfer_engine.sv
`timescale 1ns/1ps
module sim_evt_xfer_engine;
  localparam int NSRC = 4;
  localparam int CAW  = 6;

  logic            clk = 0, rst_n = 0;
  logic [NSRC-1:0] req = '0, req_clr, irq, set_req = '0, clr_man = '0;
  logic            busy, bus_valid, bus_we, bus_ready = 0;
  logic [1:0]      bus_size;
  logic [15:0]     bus_addr, bus_wdata, bus_rdata, cfg_wdata = '0, cfg_rdata;
  logic            cfg_we = 0;
  logic [CAW-1:0]  cfg_waddr = '0, cfg_raddr = '0;
  logic            stall = 0, tick = 0, cpu_ack = 0;

  logic [15:0] mem [256];
  logic [15:0] wlog [64];
  int wn = 0, checks = 0, fails = 0, hs_err = 0, wd = 0;
  int n_irq [NSRC], n_clr [NSRC];
  logic        pend = 0;
  logic [15:0] pend_addr = '0;

  evt_xfer_engine u0 (.*);

  always #10 clk = ~clk;

  assign bus_rdata = mem[bus_addr[7:0]];

  always @(negedge clk) begin
    tick = ~tick;
    bus_ready = bus_valid && (!stall || tick);
  end

  initial for (int s = 0; s < NSRC; s++) begin n_irq[s] = 0; n_clr[s] = 0; end

  always @(posedge clk) begin
    req <= (req | set_req) & ~(req_clr | (cpu_ack ? irq : '0) | clr_man);
    for (int s = 0; s < NSRC; s++) begin
      if (irq[s]) n_irq[s] <= n_irq[s] + 1;
      if (req_clr[s]) n_clr[s] <= n_clr[s] + 1;
    end
    if (bus_valid && bus_ready && bus_we) begin
      mem[bus_addr[7:0]] <= bus_wdata;
      wlog[wn[5:0]] <= bus_addr;
      wn <= wn + 1;
    end
    if (rst_n && pend && !(bus_valid && bus_addr == pend_addr)) hs_err <= hs_err + 1;
    pend <= bus_valid && !bus_ready;
    pend_addr <= bus_addr;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  task automatic wcfg(input int a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_waddr = CAW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rcfg(input string tag, input int a, input logic [15:0] exp);
    @(negedge clk);
    cfg_raddr = CAW'(a);
    #1 chk(tag, {16'h0, cfg_rdata}, {16'h0, exp});
  endtask

  task automatic set_desc(input int k, input logic [15:0] m, s, d, c);
    wcfg(4*k, m); wcfg(4*k+1, s); wcfg(4*k+2, d); wcfg(4*k+3, c);
  endtask

  task automatic fire(input int s, input string tag);
    bit seen = 0;
    @(negedge clk); set_req = NSRC'(1) << s;
    @(negedge clk); set_req = '0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (busy) seen = 1;
      if (seen && !busy) break;
    end
    chk({tag, " R12 busy seen and released"}, {30'h0, seen, busy}, {30'h0, 1'b1, 1'b0});
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset busy", {31'h0, busy}, 0);
    chk("R11 reset bus_valid", {31'h0, bus_valid}, 0);
    chk("R6 reset irq", {28'h0, irq}, 0);
    rcfg("R2 reset enable mask", 36, 16'h0000);
  endtask

  task automatic t_stream();
    int c0, i0;
    wcfg(32, 16'd2);
    set_desc(2, 16'h0008, 16'h0010, 16'h0040, 16'd3);
    wcfg(36, 16'h0001);
    mem[8'h10] = 16'hA5A5;
    c0 = n_clr[0]; i0 = n_irq[0];
    fire(0, "t_stream#1");
    chk("R3 data moved", {16'h0, mem[8'h40]}, 32'hA5A5);
    rcfg("R4 fixed source kept", 9, 16'h0010);
    rcfg("R4 destination +1", 10, 16'h0041);
    rcfg("R5 count decremented", 11, 16'd2);
    chk("R7 clear pulse", n_clr[0] - c0, 1);
    chk("R7 no irq", n_irq[0] - i0, 0);
    mem[8'h10] = 16'h1234;
    fire(0, "t_stream#2");
    chk("R3 second word", {16'h0, mem[8'h41]}, 32'h1234);
    c0 = n_clr[0]; i0 = n_irq[0];
    fire(0, "t_stream#3");
    chk("R6 irq at end", n_irq[0] - i0, 1);
    chk("R6 no clear at end", n_clr[0] - c0, 0);
    rcfg("R6 enable cleared", 36, 16'h0000);
    chk("R6 request left set", {31'h0, req[0]}, 1);
    c0 = wn;
    repeat (10) @(negedge clk);
    chk("R1 disabled source idle", wn - c0, 0);
    @(negedge clk); clr_man = 4'h1;
    @(negedge clk); clr_man = 4'h0;
  endtask

  task automatic t_word_stall();
    int h0;
    wcfg(33, 16'd4);
    set_desc(4, 16'h004E, 16'h0020, 16'h0080, 16'd5);
    wcfg(36, 16'h0002);
    mem[8'h20] = 16'hBEEF;
    stall = 1; h0 = hs_err;
    fire(1, "t_word_stall");
    stall = 0;
    chk("R3 word moved under stall", {16'h0, mem[8'h80]}, 32'hBEEF);
    rcfg("R4 source +2", 17, 16'h0022);
    rcfg("R4 destination -2", 18, 16'h007E);
    rcfg("R5 count 5->4", 19, 16'd4);
    chk("R11 beat held while stalled", hs_err - h0, 0);
  endtask

  task automatic t_priority();
    int w0, c2, c3;
    wcfg(34, 16'd0); wcfg(35, 16'd1);
    set_desc(0, 16'h0008, 16'h0050, 16'h00D0, 16'd8);
    set_desc(1, 16'h0008, 16'h0051, 16'h00E0, 16'd8);
    wcfg(36, 16'h000C);
    w0 = wn; c2 = n_clr[2]; c3 = n_clr[3];
    @(negedge clk); set_req = 4'hC;
    @(negedge clk); set_req = '0;
    repeat (30) @(negedge clk);
    chk("R1 two writes", wn - w0, 2);
    chk("R1 source 2 first", {16'h0, wlog[w0[5:0]]}, 32'h00D0);
    chk("R1 source 3 second", {16'h0, wlog[w0[5:0]+6'd1]}, 32'h00E0);
    chk("R7 both cleared", (n_clr[2] - c2) + (n_clr[3] - c3), 2);
  endtask

  task automatic t_percpu();
    int c0, i0;
    wcfg(0, 16'h0208);
    wcfg(36, 16'h0004);
    cpu_ack = 1;
    c0 = n_clr[2]; i0 = n_irq[2];
    fire(2, "t_percpu");
    cpu_ack = 0;
    chk("R8 irq per transfer", n_irq[2] - i0, 1);
    chk("R8 no clear pulse", n_clr[2] - c0, 0);
    rcfg("R8 count 7->6", 3, 16'd6);
    rcfg("R8 enable kept", 36, 16'h0004);
  endtask

  task automatic t_chain();
    int w0, c0, i0;
    wcfg(32, 16'd5);
    set_desc(5, 16'h0188, 16'h0030, 16'h0090, 16'd1);
    set_desc(6, 16'h0008, 16'h0031, 16'h00A0, 16'd4);
    wcfg(36, 16'h0001);
    mem[8'h30] = 16'h1111; mem[8'h31] = 16'h2222;
    w0 = wn; c0 = n_clr[0]; i0 = n_irq[0];
    fire(0, "t_chain");
    chk("R9 two links in one activation", wn - w0, 2);
    chk("R9 first link data", {16'h0, mem[8'h90]}, 32'h1111);
    chk("R9 second link data", {16'h0, mem[8'hA0]}, 32'h2222);
    rcfg("R9 first link count 0", 23, 16'd0);
    rcfg("R4 step 4 on first link", 22, 16'h0094);
    rcfg("R9 second link count", 27, 16'd3);
    rcfg("R9 enable kept", 36, 16'h0001);
    chk("R9 clear from last link", n_clr[0] - c0, 1);
    chk("R9 no irq", n_irq[0] - i0, 0);
  endtask

  task automatic t_repeat();
    int c0, i0;
    wcfg(35, 16'd7);
    set_desc(7, 16'h0018, 16'h0060, 16'h00C0, 16'h0303);
    wcfg(36, 16'h0008);
    mem[8'h60] = 16'h7777;
    c0 = n_clr[3]; i0 = n_irq[3];
    fire(3, "t_repeat#1");
    rcfg("R10 count 3->2", 31, 16'h0302);
    rcfg("R10 destination advanced", 30, 16'h00C1);
    fire(3, "t_repeat#2");
    fire(3, "t_repeat#3");
    chk("R10 third word", {16'h0, mem[8'hC2]}, 32'h7777);
    rcfg("R10 destination rewound", 30, 16'h00C0);
    rcfg("R10 count reloaded", 31, 16'h0303);
    rcfg("R10 enable kept", 36, 16'h0008);
    chk("R10 no irq", n_irq[3] - i0, 0);
    chk("R10 clear each time", n_clr[3] - c0, 3);
  endtask

  initial begin
    t_reset();
    t_stream();
    t_word_stall();
    t_priority();
    t_percpu();
    t_chain();
    t_repeat();
    finish_run();
  end
endmodule